// File: doc/BRIEF.md
# Battery Protection Controller Register Bank

This block is the host-visible control store of a battery-pack protection controller. A host writes and reads two byte-wide registers over a plain register port made of an address, write data, a write strobe and combinational read data. The output-control register drives the enables of the discharge switch, the charge switch, the zero-volt-charge switch and an open-drain pull-down. The state-control register carries the sleep request, the ship request and the watchdog-disable control.

The output-control register also carries a release bit for the latched current-limit and watchdog faults. The faults themselves are latched elsewhere. This block only recognises a complete set-then-clear sequence of the bit written by the host, and answers it with a one-cycle clear pulse. A strap input chooses whether the charge switch comes out of reset enabled. The ship output becomes active only while the ship request is set and the pack supply is absent. The pack-present input is asynchronous and passes through a synchroniser before it is used.

All state uses a synchronous, active-low reset, so the strap value is loaded while reset is held and the clock runs.

Top module: `pprot_regbank`

## Requirements
- R1: While reset is held, the output-control register loads 0 in bits 4:0 except bit 2, and the state-control register loads 0. The outputs then read: discharge off, zero-volt-charge on, open-drain released, sleep, ship, watchdog-disable and clear pulse all low.
- R2: A write strobe at address 0x01 stores write-data bits 4:0 in the output-control register at that clock edge. A read of 0x01 returns those bits, with bits 7:5 reading 0.
- R3: The discharge enable follows bit 1, the charge enable follows bit 2, and the open-drain pull follows bit 4 of the output-control register (1 means on or pulling).
- R4: Bit 3 of the output-control register has inverted sense. The zero-volt-charge enable output is high when the bit is 0 and low when it is 1.
- R5: The fault clear output is high for exactly the one cycle after a write to 0x01 that has write-data bit 0 equal to 0 while the stored bit 0 is 1. A write that keeps bit 0 at 1, or writes 0 while it is already 0, gives no pulse.
- R6: A write at address 0x02 stores bit 0 (sleep), bit 1 (ship request) and bit 2 (watchdog disable). Reads of 0x02 return them with bits 7:3 as 0. The sleep and watchdog-disable outputs follow their bits.
- R7: The ship output is a register loaded each cycle with (ship bit AND NOT synchronised pack-present). The pack-present input passes through a two-flop synchroniser, so a change on it reaches the ship output on the third clock edge.
- R8: Reads of any address other than 0x01 and 0x02 return 0x00, and writes to them change no register or output.
- R9: The strap input sets the reset value of output-control bit 2: 0 gives the charge switch off, 1 gives it on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pack_i | input | 1 | Strap choosing the charge-enable reset value |
| pack_present_i | input | 1 | Asynchronous pack supply present indication |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| dsg_en_o | output | 1 | Discharge switch enable |
| chg_en_o | output | 1 | Charge switch enable |
| zvc_on_o | output | 1 | Zero-volt-charge switch enable |
| odrain_pull_o | output | 1 | Open-drain output pulls low when 1 |
| sleep_o | output | 1 | Sleep request level |
| ship_o | output | 1 | Effective ship request |
| wd_dis_o | output | 1 | Watchdog disable level |
| fault_clr_o | output | 1 | One-cycle fault latch clear pulse |

## Verification
The fault clear pulse and a change of the switch enables can come from one write. The bench provokes this by arming bit 0 and then writing a value with bit 0 low and the discharge and charge bits high. It then expects the pulse and both new enables in the same cycle. A second pairing is a ship-bit write that lands in the cycle where a pack-present change leaves the synchroniser. The behavioural model in the bench settles this on every clock: it delays pack-present through its own two-entry history and applies the old register value.

// File: rtl/pprot_pkg.sv
package pprot_pkg;

  typedef struct packed {
    logic odrain;
    logic zvc_off;
    logic chg;
    logic dsg;
    logic rel;
  } oc_t;

  typedef struct packed {
    logic wd_dis;
    logic ship;
    logic sleep;
  } sc_t;

  localparam int unsigned OC_BITS = $bits(oc_t);
  localparam int unsigned SC_BITS = $bits(sc_t);

  function automatic oc_t oc_reset(input logic strap);
    oc_t v;
    v     = '0;
    v.chg = strap;
    return v;
  endfunction

  function automatic logic release_seen(input logic hit, input logic armed,
                                        input logic new_bit);
    return hit && armed && !new_bit;
  endfunction

  function automatic logic ship_effective(input logic ship_req,
                                          input logic pack_on);
    return ship_req && !pack_on;
  endfunction

endpackage

// File: rtl/pprot_sync.sv
module pprot_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pprot_outctl.sv
module pprot_outctl
  import pprot_pkg::*;
#(
  parameter int unsigned         ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]   OC_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_pack_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OC_BITS-1:0] wdata_i,
  input  logic              we_i,
  output oc_t               oc_o,
  output logic              clr_o
);
  oc_t  oc_q;
  logic clr_q;
  logic wr_hit;
  logic rel_fall;

  assign wr_hit   = we_i && (addr_i == OC_ADDR);
  assign rel_fall = release_seen(wr_hit, oc_q.rel, wdata_i[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_q  <= oc_reset(strap_pack_i);
      clr_q <= 1'b0;
    end else begin
      if (wr_hit) oc_q <= oc_t'(wdata_i);
      clr_q <= rel_fall;
    end
  end

  assign oc_o  = oc_q;
  assign clr_o = clr_q;

  // R2: a write lands in the register at the next edge
  p_oc_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (oc_q == $past(wdata_i)));

  // R8: without a hit the register keeps its value
  p_oc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(oc_q));

  // R5: the clear pulse lasts one cycle
  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

  // R5: a pulse follows an armed bit that is now cleared
  p_clr_after_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> ($past(oc_q.rel) && !oc_q.rel));
endmodule

// File: rtl/pprot_statectl.sv
module pprot_statectl
  import pprot_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]  SC_ADDR     = 'h02,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pack_present_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SC_BITS-1:0] wdata_i,
  input  logic              we_i,
  output sc_t               sc_o,
  output logic              ship_o
);
  sc_t  sc_q;
  logic ship_q;
  logic pack_s;
  logic wr_hit;

  pprot_sync #(.STAGES(SYNC_STAGES)) i_pack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pack_present_i),
    .q_o   (pack_s)
  );

  assign wr_hit = we_i && (addr_i == SC_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q   <= '0;
      ship_q <= 1'b0;
    end else begin
      if (wr_hit) sc_q <= sc_t'(wdata_i);
      ship_q <= ship_effective(sc_q.ship, pack_s);
    end
  end

  assign sc_o   = sc_q;
  assign ship_o = ship_q;

  // R6: state register takes the written bits
  p_sc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (sc_q == $past(wdata_i)));

  // R7: ship needs the request bit one cycle earlier
  p_ship_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ship_q |-> $past(sc_q.ship));

  // R7: ship needs the pack absent at the synchroniser output
  p_ship_pack_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ship_q |-> $past(!pack_s));
endmodule

// File: rtl/pprot_regbank.sv
module pprot_regbank
  import pprot_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 8,
  parameter int unsigned        DATA_W      = 8,
  parameter logic [ADDR_W-1:0]  OC_ADDR     = 'h01,
  parameter logic [ADDR_W-1:0]  SC_ADDR     = 'h02,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_pack_i,
  input  logic              pack_present_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              dsg_en_o,
  output logic              chg_en_o,
  output logic              zvc_on_o,
  output logic              odrain_pull_o,
  output logic              sleep_o,
  output logic              ship_o,
  output logic              wd_dis_o,
  output logic              fault_clr_o
);
  localparam int unsigned OC_PAD = DATA_W - OC_BITS;
  localparam int unsigned SC_PAD = DATA_W - SC_BITS;

  oc_t  oc;
  sc_t  sc;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:OC_BITS];

  pprot_outctl #(.ADDR_W(ADDR_W), .OC_ADDR(OC_ADDR)) i_outctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_pack_i (strap_pack_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i[OC_BITS-1:0]),
    .we_i         (bus_we_i),
    .oc_o         (oc),
    .clr_o        (fault_clr_o)
  );

  pprot_statectl #(.ADDR_W(ADDR_W), .SC_ADDR(SC_ADDR),
                   .SYNC_STAGES(SYNC_STAGES)) i_statectl (
    .clk            (clk),
    .rst_n          (rst_n),
    .pack_present_i (pack_present_i),
    .addr_i         (bus_addr_i),
    .wdata_i        (bus_wdata_i[SC_BITS-1:0]),
    .we_i           (bus_we_i),
    .sc_o           (sc),
    .ship_o         (ship_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OC_ADDR)      bus_rdata_o = {{OC_PAD{1'b0}}, oc};
    else if (bus_addr_i == SC_ADDR) bus_rdata_o = {{SC_PAD{1'b0}}, sc};
  end

  assign dsg_en_o      = oc.dsg;
  assign chg_en_o      = oc.chg;
  assign zvc_on_o      = ~oc.zvc_off;
  assign odrain_pull_o = oc.odrain;
  assign sleep_o       = sc.sleep;
  assign wd_dis_o      = sc.wd_dis;

  // R8: unused addresses read zero
  p_unused_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr_i != OC_ADDR) && (bus_addr_i != SC_ADDR)) |-> (bus_rdata_o == '0));

  // R6: reserved state bits read zero
  p_sc_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == SC_ADDR) |-> (bus_rdata_o[DATA_W-1:SC_BITS] == '0));

  // R4: the zero-volt switch can only turn off through a write to bit 3
  p_zvc_off_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zvc_on_o) |-> $past(bus_we_i && (bus_addr_i == OC_ADDR) && bus_wdata_i[3]));
endmodule

// File: tb/test_pprot_regbank.sv
`timescale 1ns/1ps
module test_pprot_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       pack = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic dsg, chg, zvc, od, slp, shp, wdd, clr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pprot_regbank i_pprot_regbank (
    .clk(clk), .rst_n(rst_n), .strap_pack_i(strap), .pack_present_i(pack),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
    .dsg_en_o(dsg), .chg_en_o(chg), .zvc_on_o(zvc), .odrain_pull_o(od),
    .sleep_o(slp), .ship_o(shp), .wd_dis_o(wdd), .fault_clr_o(clr)
  );

  // behavioural reference model
  int   m_oc = 0, m_sc = 0;
  bit   m_clr = 0, m_ship = 0, m_valid = 0;
  bit   pack_hist[$];

  always @(posedge clk) begin
    int nb_oc, nb_sc;
    bit nb_clr, nb_ship;
    if (!rst_n) begin
      m_oc = strap ? 4 : 0; m_sc = 0; m_clr = 0; m_ship = 0;
      pack_hist = '{0, 0};
    end else begin
      nb_oc = m_oc; nb_sc = m_sc;
      nb_clr = we && addr == 8'h01 && wdata[0] == 0 && (m_oc % 2 == 1);
      nb_ship = ((m_sc / 2) % 2 == 1) && !pack_hist[1];
      if (we && addr == 8'h01) nb_oc = wdata % 32;
      if (we && addr == 8'h02) nb_sc = wdata % 8;
      pack_hist.push_front(pack);
      void'(pack_hist.pop_back());
      m_oc = nb_oc; m_sc = nb_sc; m_clr = nb_clr; m_ship = nb_ship;
    end
    m_valid = 1;
  end

  task automatic chk(string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd;
    if (m_valid && rst_n) begin
      exp_rd = (addr == 8'h01) ? m_oc : (addr == 8'h02) ? m_sc : 0;
      chk("R2/R6/R8 rdata", rdata, exp_rd);
      chk("R3 dsg", dsg, (m_oc / 2) % 2);
      chk("R3 chg", chg, (m_oc / 4) % 2);
      chk("R4 zvc", zvc, 1 - (m_oc / 8) % 2);
      chk("R3 od", od, (m_oc / 16) % 2);
      chk("R5 clr", clr, m_clr);
      chk("R6 sleep", slp, m_sc % 2);
      chk("R6 wd_dis", wdd, (m_sc / 4) % 2);
      chk("R7 ship", shp, m_ship);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic do_reset(bit s);
    rst_n = 1'b0; strap = s; we = 1'b0;
    step(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dsg off", dsg, 0);
    chk("R9 chg from strap", chg, s);
    chk("R1 zvc on", zvc, 1);
    chk("R1 od released", od, 0);
    chk("R1 sleep", slp, 0);
    chk("R1 ship", shp, 0);
    chk("R1 wd_dis", wdd, 0);
    chk("R1 clr", clr, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    do_reset(0);
    // R2 R3 R4: enable switches, turn zero-volt switch off
    wr(8'h01, 8'h1E); addr = 8'h01;
    @(negedge clk);
    chk("R2 readback", rdata, 8'h1E);
    chk("R4 zvc off", zvc, 0);
    @(posedge clk); #1;
    // R5: arm, hold at 1, then release
    wr(8'h01, 8'h1F); wr(8'h01, 8'h1F);
    @(negedge clk); chk("R5 no clr while held", clr, 0);
    @(posedge clk); #1;
    wr(8'h01, 8'h1E);
    @(negedge clk); chk("R5 clr pulse", clr, 1);
    @(negedge clk); chk("R5 clr one cycle", clr, 0);
    @(posedge clk); #1;
    wr(8'h01, 8'h1E); wr(8'h01, 8'h00);
    @(negedge clk); chk("R5 no clr from 0", clr, 0);
    @(posedge clk); #1;
    // same-cycle clear and enable change
    wr(8'h01, 8'h01); wr(8'h01, 8'h06);
    @(negedge clk);
    chk("R5 clr with enables", clr, 1);
    chk("R3 dsg with clr", dsg, 1);
    chk("R3 chg with clr", chg, 1);
    @(posedge clk); #1;
    wr(8'h01, 8'hFF); addr = 8'h01;
    @(negedge clk); chk("R2 high bits zero", rdata, 8'h1F);
    @(posedge clk); #1;
    // R6 R7
    wr(8'h02, 8'hFF); addr = 8'h02;
    @(negedge clk);
    chk("R6 readback", rdata, 8'h07);
    chk("R7 ship blocked by pack", shp, 0);
    @(posedge clk); #1;
    pack = 1'b0;
    step(2);
    @(negedge clk); chk("R7 ship not yet", shp, 0);
    @(negedge clk); chk("R7 ship on third edge", shp, 1);
    @(posedge clk); #1;
    pack = 1'b1; step(1);
    wr(8'h02, 8'h00); step(3);
    pack = 1'b0; step(1); wr(8'h02, 8'h02); step(5);
    // R8 unused addresses
    wr(8'h05, 8'hFF); wr(8'h00, 8'hFF); wr(8'h03, 8'hFF);
    addr = 8'h03;
    @(negedge clk); chk("R8 unused read", rdata, 0);
    @(posedge clk); #1;
    addr = 8'h01;
    @(negedge clk); chk("R8 oc untouched", rdata, 8'h1F);
    @(posedge clk); #1;
    // mixed traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      addr  = 8'(lfsr % 4);
      wdata = 8'(lfsr >> 3);
      we    = (lfsr / 64) % 3 != 0;
      if ((lfsr / 512) % 7 == 0) pack = ~pack;
      step(1);
    end
    we = 1'b0;
    do_reset(1);
    chk("R9 strap high reset", chg, 1);
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule